// File: doc/BRIEF.md
# Daughterboard Pin Controller with Automatic Transmit/Receive Switching

This block drives four banks of sixteen general-purpose pins that run to plug-in radio boards. Software programs it through a small write-only register port. Each pin has a direction bit and an output level. Both are set through a masked write: the top half of the data word picks the bits to change and the bottom half gives their new values. Bits that are not picked keep their old values.

Each bank can also switch some of its pins on its own when the radio changes between sending and receiving. A per-bank switching mask picks the pins that take part. While the transmit FIFO holds data, those pins show a transmit pattern. Once the FIFO is empty they show a receive pattern. The FIFO-empty flag is registered once before use. A per-bank debug-enable bit gives one bank to an internal debug bus. That bus then drives the bank's pin levels, and every pin of the bank becomes an output.

Top module: `dbio_ctrl`

## Requirements
- R1: After reset every register reads as zero, so `pin_oe` and `pin_out` are all zero.
- R2: A write to address 5+b (bank b = 0..3) changes only those direction bits of bank b whose mask bit `wr_data[16+i]` is 1, setting them to `wr_data[i]`. A direction bit of 1 makes `pin_oe` bit 16*b+i high.
- R3: A write to address 9+b changes the output-level register of bank b with the same masked rule as R2.
- R4: While switching is off for bank b, `pin_out` for bank b equals its output-level register, whatever the switching registers and the FIFO flag hold.
- R5: While switching is on for bank b and the registered FIFO flag says data is present, each pin whose switching-mask bit is 1 takes its transmit-pattern bit. Every other pin takes its output-level bit.
- R6: While switching is on for bank b and the registered flag says the FIFO is empty, each masked pin takes its receive-pattern bit.
- R7: A change on `txfifo_empty` reaches `pin_out` after exactly one rising clock edge, never in the same cycle.
- R8: Address 14 bits [3:0] are debug enables, one per bank. With bit b set, bank b drives all-ones on `pin_oe` and `dbg_data[16*b+15:16*b]` on `pin_out`. Other banks are unchanged.
- R9: A write to any address other than 5..14 and 20..31 changes no register.
- R10: Address 13 bits [3:0] are switching enables, one per bank, and each bit acts only on its own bank. The switching mask, transmit pattern and receive pattern of bank b sit at 20+3b, 21+3b and 22+3b, and each takes `wr_data[15:0]`.
- R11: A register write takes effect on the outputs after the rising edge at which `wr_en` is sampled high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register address |
| wr_data | input | 32 | Write data: mask in the top half, value in the bottom half for masked registers |
| txfifo_empty | input | 1 | High when the transmit FIFO holds no data |
| dbg_data | input | 64 | Debug bus levels, 16 bits per bank |
| pin_oe | output | 64 | Per-pin output enable, 16 bits per bank |
| pin_out | output | 64 | Per-pin output level, 16 bits per bank |

## Verification
A register write and a FIFO flag change can land in the same cycle. When they do, the new level on a switched pin depends on both. The table walk makes this happen on purpose: several vectors write the switching-enable register while `txfifo_empty` changes on the same edge. The expected output is then worked out from the state both changes leave behind. A directed step also changes the flag with no write at all. It then checks that the old level is still present before the edge and that the new one appears after it.

// File: rtl/dbio_pkg.sv
package dbio_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = 16;
    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 32;

    // register addresses that the map depends on
    localparam int DIR_BASE  = 5;
    localparam int LVL_BASE  = 9;
    localparam int SW_CTL    = 13;
    localparam int DBG_CTL   = 14;
    localparam int SW_BASE   = 20;
    localparam int SW_STRIDE = 3;

    typedef struct packed {
        logic [BANK_W-1:0] dir;
        logic [BANK_W-1:0] lvl;
        logic [BANK_W-1:0] sw_mask;
        logic [BANK_W-1:0] sw_tx;
        logic [BANK_W-1:0] sw_rx;
    } bank_regs_t;

    typedef enum logic [1:0] {
        SRC_LEVEL = 2'd0,
        SRC_SWITCH = 2'd1,
        SRC_DEBUG = 2'd2
    } pin_src_e;

    function automatic logic [BANK_W-1:0] masked_merge(
        input logic [BANK_W-1:0] old_v,
        input logic [BANK_W-1:0] mask,
        input logic [BANK_W-1:0] new_v
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/dbio_flag_reg.sv
module dbio_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic fifo_empty_i,
    output logic fifo_busy_o
);
    logic empty_q;

    always_ff @(posedge clk) begin
        if (rst) empty_q <= 1'b1;
        else     empty_q <= fifo_empty_i;
    end

    assign fifo_busy_o = ~empty_q;
endmodule

// File: rtl/dbio_regfile.sv
module dbio_regfile
    import dbio_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int BW = BANK_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    output bank_regs_t [NB-1:0]       regs_o,
    output logic [NB-1:0]             sw_en_o,
    output logic [NB-1:0]             dbg_en_o
);
    localparam int MASK_LSB = BW;

    bank_regs_t [NB-1:0] regs_q;
    logic [NB-1:0]       sw_en_q;
    logic [NB-1:0]       dbg_en_q;

    wire [BW-1:0] wr_mask = wr_data[MASK_LSB +: BW];
    wire [BW-1:0] wr_val  = wr_data[BW-1:0];

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_bank
            localparam logic [AW-1:0] A_DIR = AW'(DIR_BASE + b);
            localparam logic [AW-1:0] A_LVL = AW'(LVL_BASE + b);
            localparam logic [AW-1:0] A_MSK = AW'(SW_BASE + SW_STRIDE*b);
            localparam logic [AW-1:0] A_TX  = AW'(SW_BASE + SW_STRIDE*b + 1);
            localparam logic [AW-1:0] A_RX  = AW'(SW_BASE + SW_STRIDE*b + 2);

            always_ff @(posedge clk) begin
                if (rst) begin
                    regs_q[b] <= '0;
                end else if (wr_en) begin
                    if (wr_addr == A_DIR)
                        regs_q[b].dir <= masked_merge(regs_q[b].dir, wr_mask, wr_val);
                    if (wr_addr == A_LVL)
                        regs_q[b].lvl <= masked_merge(regs_q[b].lvl, wr_mask, wr_val);
                    if (wr_addr == A_MSK)
                        regs_q[b].sw_mask <= wr_val;
                    if (wr_addr == A_TX)
                        regs_q[b].sw_tx <= wr_val;
                    if (wr_addr == A_RX)
                        regs_q[b].sw_rx <= wr_val;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_en_q  <= '0;
            dbg_en_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(SW_CTL))  sw_en_q  <= wr_data[NB-1:0];
            if (wr_addr == AW'(DBG_CTL)) dbg_en_q <= wr_data[NB-1:0];
        end
    end

    assign regs_o   = regs_q;
    assign sw_en_o  = sw_en_q;
    assign dbg_en_o = dbg_en_q;
endmodule

// File: rtl/dbio_bank_mux.sv
module dbio_bank_mux
    import dbio_pkg::*;
#(
    parameter int BW = BANK_W
) (
    input  bank_regs_t    regs_i,
    input  logic          sw_en_i,
    input  logic          dbg_en_i,
    input  logic          fifo_busy_i,
    input  logic [BW-1:0] dbg_i,
    output logic [BW-1:0] oe_o,
    output logic [BW-1:0] out_o
);
    pin_src_e      src;
    logic [BW-1:0] sw_sel;
    logic [BW-1:0] sw_val;
    logic [BW-1:0] mixed;

    always_comb begin
        if (dbg_en_i)     src = SRC_DEBUG;
        else if (sw_en_i) src = SRC_SWITCH;
        else              src = SRC_LEVEL;
    end

    always_comb begin
        sw_sel = regs_i.sw_mask;
        sw_val = fifo_busy_i ? regs_i.sw_tx : regs_i.sw_rx;
        mixed  = (sw_val & sw_sel) | (regs_i.lvl & ~sw_sel);
        unique case (src)
            SRC_DEBUG: begin
                oe_o  = '1;
                out_o = dbg_i;
            end
            SRC_SWITCH: begin
                oe_o  = regs_i.dir;
                out_o = mixed;
            end
            default: begin
                oe_o  = regs_i.dir;
                out_o = regs_i.lvl;
            end
        endcase
    end
endmodule

// File: rtl/dbio_ctrl.sv
module dbio_ctrl
    import dbio_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int BW = BANK_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    localparam int PW = NB * BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          txfifo_empty,
    input  logic [PW-1:0] dbg_data,
    output logic [PW-1:0] pin_oe,
    output logic [PW-1:0] pin_out
);
    bank_regs_t [NB-1:0] regs;
    logic [NB-1:0]       sw_en;
    logic [NB-1:0]       dbg_en;
    logic                fifo_busy;

    dbio_flag_reg u_flag (
        .clk          (clk),
        .rst          (rst),
        .fifo_empty_i (txfifo_empty),
        .fifo_busy_o  (fifo_busy)
    );

    dbio_regfile #(.NB(NB), .BW(BW), .AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .regs_o   (regs),
        .sw_en_o  (sw_en),
        .dbg_en_o (dbg_en)
    );

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_mux
            dbio_bank_mux #(.BW(BW)) u_mux (
                .regs_i      (regs[b]),
                .sw_en_i     (sw_en[b]),
                .dbg_en_i    (dbg_en[b]),
                .fifo_busy_i (fifo_busy),
                .dbg_i       (dbg_data[b*BW +: BW]),
                .oe_o        (pin_oe[b*BW +: BW]),
                .out_o       (pin_out[b*BW +: BW])
            );
        end
    endgenerate
endmodule

// File: rtl/dbio_ctrl_chk.sv
module dbio_ctrl_chk
    import dbio_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int BW = BANK_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    localparam int PW = NB * BW
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [AW-1:0]       wr_addr,
    input logic [DW-1:0]       wr_data,
    input logic [PW-1:0]       dbg_data,
    input logic [PW-1:0]       pin_oe,
    input logic [PW-1:0]       pin_out,
    input bank_regs_t [NB-1:0] regs,
    input logic [NB-1:0]       sw_en,
    input logic [NB-1:0]       dbg_en
);
    wire unmapped = !((wr_addr >= AW'(DIR_BASE) && wr_addr <= AW'(DBG_CTL)) ||
                      (wr_addr >= AW'(SW_BASE) && wr_addr < AW'(SW_BASE + SW_STRIDE*NB)));

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (pin_oe == '0 && pin_out == '0));

    assert_unmapped_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en && unmapped |=> $stable(pin_oe));

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_chk
            assert_dir_masked_R2: assert property (@(posedge clk) disable iff (rst)
                wr_en && wr_addr == AW'(DIR_BASE + b) && !dbg_en[b] |=>
                (((pin_oe[b*BW +: BW] ^ $past(wr_data[BW-1:0])) &
                  $past(wr_data[BW +: BW])) == '0));

            assert_level_when_off_R4: assert property (@(posedge clk) disable iff (rst)
                !sw_en[b] && !dbg_en[b] |-> pin_out[b*BW +: BW] == regs[b].lvl);

            assert_debug_owns_bank_R8: assert property (@(posedge clk) disable iff (rst)
                dbg_en[b] |-> (pin_oe[b*BW +: BW] == '1 &&
                               pin_out[b*BW +: BW] == dbg_data[b*BW +: BW]));
        end
    endgenerate
endmodule

bind dbio_ctrl dbio_ctrl_chk #(.NB(NB), .BW(BW), .AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .dbg_data (dbg_data),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .regs     (regs),
    .sw_en    (sw_en),
    .dbg_en   (dbg_en)
);

// File: tb/tb_dbio_ctrl.sv
module tb_dbio_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        txfifo_empty = 1'b1;
    logic [63:0] dbg_data = 64'hDEAD_BEEF_CAFE_F00D;
    logic [63:0] pin_oe;
    logic [63:0] pin_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbio_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .txfifo_empty(txfifo_empty), .dbg_data(dbg_data),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    typedef struct packed {
        logic [6:0]  a;
        logic [31:0] d;
        logic        fe;
        logic [63:0] oe;
        logic [63:0] out;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{7'd5,  32'hFFFF_00FF, 1'b1, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0000}, // R2
        '{7'd5,  32'h0F00_0F0F, 1'b1, 64'h0000_0000_0000_0FFF, 64'h0000_0000_0000_0000}, // R2 masked
        '{7'd9,  32'hFFFF_1234, 1'b1, 64'h0000_0000_0000_0FFF, 64'h0000_0000_0000_1234}, // R3
        '{7'd9,  32'h00F0_FFFF, 1'b1, 64'h0000_0000_0000_0FFF, 64'h0000_0000_0000_12F4}, // R3 masked
        '{7'd20, 32'h0000_FF00, 1'b1, 64'h0000_0000_0000_0FFF, 64'h0000_0000_0000_12F4}, // R4, R10
        '{7'd21, 32'h0000_AB00, 1'b1, 64'h0000_0000_0000_0FFF, 64'h0000_0000_0000_12F4}, // R4
        '{7'd22, 32'h0000_CD00, 1'b1, 64'h0000_0000_0000_0FFF, 64'h0000_0000_0000_12F4}, // R4
        '{7'd13, 32'h0000_0001, 1'b0, 64'h0000_0000_0000_0FFF, 64'h0000_0000_0000_ABF4}, // R5
        '{7'd3,  32'hFFFF_FFFF, 1'b1, 64'h0000_0000_0000_0FFF, 64'h0000_0000_0000_CDF4}, // R6, R9
        '{7'd6,  32'hFFFF_8001, 1'b1, 64'h0000_0000_8001_0FFF, 64'h0000_0000_0000_CDF4}, // R2 bank 1
        '{7'd10, 32'hFFFF_5555, 1'b1, 64'h0000_0000_8001_0FFF, 64'h0000_0000_5555_CDF4}, // R3 bank 1
        '{7'd26, 32'h0000_FFFF, 1'b1, 64'h0000_0000_8001_0FFF, 64'h0000_0000_5555_CDF4}, // R4 bank 2
        '{7'd27, 32'h0000_0F0F, 1'b1, 64'h0000_0000_8001_0FFF, 64'h0000_0000_5555_CDF4}, // R4 bank 2
        '{7'd13, 32'h0000_0005, 1'b0, 64'h0000_0000_8001_0FFF, 64'h0000_0F0F_5555_ABF4}, // R10
        '{7'd13, 32'h0000_0004, 1'b0, 64'h0000_0000_8001_0FFF, 64'h0000_0F0F_5555_12F4}, // R10
        '{7'd40, 32'hFFFF_FFFF, 1'b0, 64'h0000_0000_8001_0FFF, 64'h0000_0F0F_5555_12F4}  // R9
    };

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset oe", pin_oe, 64'h0);
        check("R1 reset out", pin_out, 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = VEC[i].a; wr_data = VEC[i].d; txfifo_empty = VEC[i].fe;
            @(negedge clk);
            wr_en = 1'b0;
            check($sformatf("vec %0d oe", i), pin_oe, VEC[i].oe);
            check($sformatf("vec %0d out", i), pin_out, VEC[i].out);
        end

        // R7: flag change, no write; old level until the edge
        @(negedge clk);
        txfifo_empty = 1'b1;
        #1 check("R7 before edge", pin_out, 64'h0000_0F0F_5555_12F4);
        @(negedge clk);
        check("R7 after edge", pin_out, 64'h0000_0000_5555_12F4);

        // R11: write not seen before the edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'd12; wr_data = 32'hFFFF_BEEF;
        #1 check("R11 before edge", pin_out, 64'h0000_0000_5555_12F4);
        @(negedge clk);
        wr_en = 1'b0;
        check("R11 after edge", pin_out, 64'hBEEF_0000_5555_12F4);

        // R8: debug owns bank 1 only
        write(7'd14, 32'h0000_0002);
        check("R8 debug oe", pin_oe, 64'h0000_0000_FFFF_0FFF);
        check("R8 debug out", pin_out, 64'hBEEF_0000_CAFE_12F4);
        write(7'd14, 32'h0000_0000);
        check("R8 release oe", pin_oe, 64'h0000_0000_8001_0FFF);
        check("R8 release out", pin_out, 64'hBEEF_0000_5555_12F4);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 rereset oe", pin_oe, 64'h0);
        check("R1 rereset out", pin_out, 64'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule